// File: doc/BRIEF.md
# SMBus Command Byte and Transfer Sequencer

This block sits behind a byte-level I2C/SMBus target front end. The first byte after a write address is a command byte. Bit 7 must be set for the byte to be accepted. Bits 6:5 give the transfer type: byte, word, block, or interrupt clear. Bits 4:0 load the register pointer. Later data bytes are written to an internal register file through a single-address port, and read bytes are taken from the same port. The pointer advances by the rules of the transfer type.

Two command values get special handling. An interrupt-clear command sent alone, with no data, produces a one-cycle clear pulse after the stop. Command CFh is a block transfer at address 0Fh. A read after CFh does not touch the register file. At the start of that read, the block captures eight channel bytes into a shadow buffer. It then returns a byte count of 8, followed by the eight captured bytes in order.

Front end contract: `start_i` pulses once per start or repeated start, with `dir_rd_i` valid in that cycle. `rx_valid_i` marks a received byte. `tx_data_o` always shows the next byte to send, and `tx_req_i` pulses when the front end takes that byte.

Top module: `smb_cmd_decoder`

## Requirements
- R1: After reset the command holds 00h and the pointer holds 0. A read with no command byte reads address 0 and stays there on every byte, because type 00 is byte protocol. `reg_we_o` and `int_clr_o` are low.
- R2: The first received byte after a write start with bit 7 = 1 is the command. It loads the pointer from bits 4:0 and causes no register write.
- R3: A first byte with bit 7 = 0 is rejected. The pointer and the command are unchanged, and no data byte in that transaction is written.
- R4: Byte type (bits 6:5 = 00): only the first data byte is written, at the pointer. Reads repeat the byte at the pointer.
- R5: Word type (01): the first two data bytes are written to pointer and pointer+1, low address first, and further bytes are dropped. A read returns the pointer byte, then the pointer+1 byte, and then repeats that one.
- R6: Block type (10), other than CFh: every data byte is written at the pointer, and the pointer then advances, wrapping at 5 bits. Reads advance the same way until stop.
- R7: Interrupt-clear type (11) followed directly by stop drives `int_clr_o` high for exactly the one cycle after the stop cycle. It writes nothing.
- R8: Interrupt-clear command followed by a data byte raises no clear pulse and writes nothing.
- R9: A read after command CFh returns 08h first. It then returns channel bytes 0..7, where byte k is `chan_data_i[8k+7:8k]` and maps to register 10h+k. After those it returns 00h.
- R10: The channel bytes are captured at the read start. Later changes of `chan_data_i` do not alter the burst.
- R11: Data bytes written after command CFh are not written.
- R12: A repeated start into a read keeps the pointer and the transfer type from the preceding command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start or repeated start seen (one cycle) |
| stop_i | input | 1 | Stop seen (one cycle) |
| dir_rd_i | input | 1 | Direction with start_i: 1 = read |
| rx_valid_i | input | 1 | Received byte valid |
| rx_data_i | input | 8 | Received byte |
| tx_req_i | input | 1 | Front end consumed tx_data_o |
| tx_data_o | output | 8 | Next byte to transmit |
| reg_addr_o | output | 5 | Register file address (pointer) |
| reg_we_o | output | 1 | Register write strobe |
| reg_wdata_o | output | 8 | Register write data |
| reg_rdata_i | input | 8 | Register file read data for reg_addr_o |
| chan_data_i | input | 64 | Eight channel-data bytes, byte k at bits 8k+7:8k |
| int_clr_o | output | 1 | Interrupt clear pulse |

## Verification
Write transactions are driven with each transfer type and the same three trailing data bytes. Because the data bytes are identical, the number and addresses of the resulting writes show the difference between byte, word and block handling. They also expose a wrap at the top of the 5-bit pointer, a rejected command byte, a CFh write and an interrupt-clear carrying data.

Read phases after a repeated start tell apart:
- a pointer that holds (byte protocol),
- a pointer that steps once (word protocol),
- a pointer that steps on every byte (block protocol).

The CFh burst is read while the channel inputs change, so live reads of the inputs can be told apart from the captured copy. The interrupt clear is checked both for its pulse width and for being suppressed by a data byte.

// File: rtl/smb_cmd_pkg.sv
`timescale 1ns/1ps
package smb_cmd_pkg;
  localparam int unsigned PTR_W  = 5;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [1:0] {
    XF_BYTE  = 2'b00,
    XF_WORD  = 2'b01,
    XF_BLOCK = 2'b10,
    XF_ICLR  = 2'b11
  } xfer_e;

  typedef enum logic [2:0] {
    PH_IDLE, PH_CMD, PH_WR, PH_SKIP, PH_RD
  } phase_e;

  typedef struct packed {
    logic             sel;
    xfer_e            xfer;
    logic [PTR_W-1:0] addr;
  } cmd_t;
endpackage

// File: rtl/smb_cmd_ctrl.sv
`timescale 1ns/1ps
module smb_cmd_ctrl
  import smb_cmd_pkg::*;
#(
  parameter logic [BYTE_W-1:0] BURST_CMD = 8'hCF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              dir_rd_i,
  input  logic              rx_valid_i,
  input  logic [BYTE_W-1:0] rx_data_i,
  input  logic              tx_req_i,
  output logic              burst_o,
  output logic              burst_cap_o,
  output logic [PTR_W-1:0]  ptr_o,
  output logic              we_o,
  output logic              int_clr_o
);
  cmd_t             cmd_q;
  phase_e           ph_q;
  logic [PTR_W-1:0] ptr_q;
  logic [1:0]       cnt_q;
  logic             arm_q;
  logic             is_burst, wr_ok, rd_step, cnt_inc;

  assign is_burst = (cmd_q == cmd_t'(BURST_CMD));

  always_comb begin
    unique case (cmd_q.xfer)
      XF_BYTE:  wr_ok = (cnt_q == 2'd0);
      XF_WORD:  wr_ok = (cnt_q < 2'd2);
      XF_BLOCK: wr_ok = !is_burst;
      default:  wr_ok = 1'b0;
    endcase
  end

  assign we_o    = rx_valid_i && (ph_q == PH_WR) && wr_ok;
  assign rd_step = tx_req_i && (ph_q == PH_RD) && !is_burst &&
                   ((cmd_q.xfer == XF_WORD && cnt_q == 2'd0) || cmd_q.xfer == XF_BLOCK);
  assign cnt_inc = (rx_valid_i && ph_q == PH_WR) || (tx_req_i && ph_q == PH_RD);

  assign burst_o     = (ph_q == PH_RD) && is_burst;
  assign burst_cap_o = start_i && dir_rd_i && is_burst;
  assign ptr_o       = ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q     <= '0;
      ph_q      <= PH_IDLE;
      ptr_q     <= '0;
      cnt_q     <= '0;
      arm_q     <= 1'b0;
      int_clr_o <= 1'b0;
    end else begin
      int_clr_o <= 1'b0;
      if (start_i) begin
        ph_q  <= dir_rd_i ? PH_RD : PH_CMD;
        cnt_q <= '0;
        arm_q <= 1'b0;
      end else if (stop_i) begin
        ph_q      <= PH_IDLE;
        int_clr_o <= arm_q;
        arm_q     <= 1'b0;
      end else begin
        if (rx_valid_i && ph_q == PH_CMD) begin
          if (rx_data_i[BYTE_W-1]) begin
            cmd_q <= cmd_t'(rx_data_i);
            ptr_q <= rx_data_i[PTR_W-1:0];
            ph_q  <= PH_WR;
            arm_q <= (rx_data_i[6:5] == XF_ICLR);
          end else begin
            ph_q <= PH_SKIP;
          end
        end
        if (rx_valid_i && ph_q == PH_WR) arm_q <= 1'b0;  // data voids send-byte clear
        if (cnt_inc && cnt_q != 2'd3) cnt_q <= cnt_q + 2'd1;
        if ((we_o && cmd_q.xfer != XF_BYTE) || rd_step) ptr_q <= ptr_q + 1'b1;
      end
    end
  end

  p_ptr_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_o && cmd_q.xfer == XF_BLOCK && !start_i && !stop_i) |=> ptr_q == $past(ptr_q) + 1'b1);
  p_reject_keep_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_CMD && rx_valid_i && !rx_data_i[BYTE_W-1] && !start_i) |=> $stable(ptr_q));
  p_clr_after_stop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_clr_o |-> $past(stop_i));
  p_clr_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_clr_o |=> !int_clr_o);
  p_byte_once_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_o && cmd_q.xfer == XF_BYTE) |=> !we_o);
endmodule

// File: rtl/smb_burst_buf.sv
`timescale 1ns/1ps
module smb_burst_buf #(
  parameter int unsigned N_CH = 8,
  parameter int unsigned DW   = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cap_i,
  input  logic               adv_i,
  input  logic [N_CH*DW-1:0] chan_i,
  output logic [DW-1:0]      byte_o
);
  localparam int unsigned IW   = $clog2(N_CH + 2);
  localparam logic [IW-1:0] LAST = IW'(N_CH + 1);

  logic [N_CH-1:0][DW-1:0] sh_q;
  logic [IW-1:0]           idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      idx_q <= '0;
    end else if (cap_i) begin
      for (int k = 0; k < int'(N_CH); k++) sh_q[k] <= chan_i[k*DW +: DW];
      idx_q <= '0;
    end else if (adv_i && idx_q != LAST) begin
      idx_q <= idx_q + 1'b1;
    end
  end

  // position 0 is the byte count, then channel bytes, then zero fill
  always_comb begin
    byte_o = '0;
    if (idx_q == '0) byte_o = DW'(N_CH);
    for (int k = 0; k < int'(N_CH); k++)
      if (idx_q == IW'(k + 1)) byte_o = sh_q[k];
  end

  p_count_first_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_i |=> byte_o == DW'(N_CH));
  p_shadow_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_i |=> $stable(sh_q));
endmodule

// File: rtl/smb_cmd_decoder.sv
`timescale 1ns/1ps
module smb_cmd_decoder
  import smb_cmd_pkg::*;
#(
  parameter int unsigned       N_CH      = 8,
  parameter logic [BYTE_W-1:0] BURST_CMD = 8'hCF
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic                   stop_i,
  input  logic                   dir_rd_i,
  input  logic                   rx_valid_i,
  input  logic [BYTE_W-1:0]      rx_data_i,
  input  logic                   tx_req_i,
  output logic [BYTE_W-1:0]      tx_data_o,
  output logic [PTR_W-1:0]       reg_addr_o,
  output logic                   reg_we_o,
  output logic [BYTE_W-1:0]      reg_wdata_o,
  input  logic [BYTE_W-1:0]      reg_rdata_i,
  input  logic [N_CH*BYTE_W-1:0] chan_data_i,
  output logic                   int_clr_o
);
  logic              burst, burst_cap;
  logic [BYTE_W-1:0] burst_byte;

  smb_cmd_ctrl #(.BURST_CMD(BURST_CMD)) u_ctrl (
    .clk_i, .rst_ni, .start_i, .stop_i, .dir_rd_i, .rx_valid_i, .rx_data_i, .tx_req_i,
    .burst_o(burst), .burst_cap_o(burst_cap), .ptr_o(reg_addr_o),
    .we_o(reg_we_o), .int_clr_o
  );

  smb_burst_buf #(.N_CH(N_CH), .DW(BYTE_W)) u_burst (
    .clk_i, .rst_ni, .cap_i(burst_cap), .adv_i(burst && tx_req_i),
    .chan_i(chan_data_i), .byte_o(burst_byte)
  );

  assign tx_data_o   = burst ? burst_byte : reg_rdata_i;
  assign reg_wdata_o = rx_data_i;
endmodule

// File: tb/sim_smb_cmd_decoder.sv
`timescale 1ns/1ps
module sim_smb_cmd_decoder;
  logic clk = 0, rst_ni = 0;
  logic start_i = 0, stop_i = 0, dir_rd_i = 0, rx_valid_i = 0, tx_req_i = 0;
  logic [7:0] rx_data_i = '0, tx_data_o, reg_wdata_o, reg_rdata_i;
  logic [4:0] reg_addr_o;
  logic reg_we_o, int_clr_o;
  logic [63:0] chan_data_i = '0;

  int n_tests = 0, n_fail = 0, n_wr = 0;
  logic [4:0] log_a [8];
  logic [7:0] log_d [8];
  logic clr_seen, clr_after, done = 0;
  logic [7:0] v;

  always #10 clk = ~clk;  // 50 MHz

  assign reg_rdata_i = 8'h40 + {3'b0, reg_addr_o};

  smb_cmd_decoder u0 (.clk_i(clk), .*);

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic do_start(logic rd);
    start_i = 1; dir_rd_i = rd; @(negedge clk); start_i = 0;
  endtask

  task automatic do_stop();
    stop_i = 1; @(negedge clk); stop_i = 0;
    clr_seen = int_clr_o; @(negedge clk); clr_after = int_clr_o;
  endtask

  task automatic send_byte(logic [7:0] b);
    rx_valid_i = 1; rx_data_i = b; #1;
    if (reg_we_o && n_wr < 8) begin log_a[n_wr] = reg_addr_o; log_d[n_wr] = reg_wdata_o; n_wr++; end
    @(negedge clk); rx_valid_i = 0;
  endtask

  task automatic read_byte(output logic [7:0] b);
    tx_req_i = 1; #1; b = tx_data_o; @(negedge clk); tx_req_i = 0;
  endtask

  // {req, cmd, expected writes}; data bytes A0,A1,A2 always sent
  localparam logic [15:0] VEC [7] = '{
    {4'd4,  8'h83, 4'd1},  // R4 byte
    {4'd5,  8'hA3, 4'd2},  // R5 word
    {4'd6,  8'hC3, 4'd3},  // R6 block
    {4'd6,  8'hDE, 4'd3},  // R6 wrap 1E,1F,00
    {4'd3,  8'h05, 4'd0},  // R3 rejected
    {4'd11, 8'hCF, 4'd0},  // R11 burst cmd write
    {4'd8,  8'hE0, 4'd0}   // R8 clear with data
  };

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset addr", {3'b0, reg_addr_o}, 8'h00);
    chk("R1 reset we", {7'b0, reg_we_o}, 8'h00);
    chk("R1 reset clr", {7'b0, int_clr_o}, 8'h00);
    rst_ni = 1; @(negedge clk);
    do_start(1);
    read_byte(v); chk("R1 read0", v, 8'h40);
    read_byte(v); chk("R1 read1 no step", v, 8'h40);
    do_stop();

    foreach (VEC[i]) begin
      automatic logic [7:0] cmd = VEC[i][11:4];
      automatic int nexp = int'(VEC[i][3:0]);
      automatic string tg = $sformatf("R%0d row%0d", VEC[i][15:12], i);
      n_wr = 0;
      do_start(0);
      send_byte(cmd);
      for (int j = 0; j < 3; j++) send_byte(8'hA0 + 8'(j));
      do_stop();
      chk({tg, " count"}, 8'(n_wr), 8'(nexp));
      for (int j = 0; j < nexp && j < n_wr; j++) begin
        chk({tg, " addr"}, {3'b0, log_a[j]}, {3'b0, cmd[4:0] + 5'(j)});
        chk({tg, " data"}, log_d[j], 8'hA0 + 8'(j));
      end
      chk({tg, " no clr"}, {7'b0, clr_seen}, 8'h00);
    end

    // R2 command loads pointer, no write
    n_wr = 0;
    do_start(0); send_byte(8'h89);
    chk("R2 ptr", {3'b0, reg_addr_o}, 8'h09);
    chk("R2 no write", 8'(n_wr), 8'h00);
    do_stop();
    // R3 rejected command keeps pointer
    do_start(0); send_byte(8'h12);
    chk("R3 ptr kept", {3'b0, reg_addr_o}, 8'h09);
    do_stop();

    // R7 send-byte interrupt clear
    n_wr = 0;
    do_start(0); send_byte(8'hE4); do_stop();
    chk("R7 pulse", {7'b0, clr_seen}, 8'h01);
    chk("R7 one cycle", {7'b0, clr_after}, 8'h00);
    chk("R7 no write", 8'(n_wr), 8'h00);

    // R12 repeated start keeps word type and pointer; R5 read order
    do_start(0); send_byte(8'hA5); do_start(1);
    read_byte(v); chk("R12 R5 rd0", v, 8'h45);
    read_byte(v); chk("R5 rd1", v, 8'h46);
    read_byte(v); chk("R5 rd2 holds", v, 8'h46);
    do_stop();
    // R4 byte read holds
    do_start(0); send_byte(8'h87); do_start(1);
    read_byte(v); chk("R4 rd0", v, 8'h47);
    read_byte(v); chk("R4 rd1", v, 8'h47);
    do_stop();
    // R6 block read wraps
    do_start(0); send_byte(8'hDF); do_start(1);
    read_byte(v); chk("R6 rd0", v, 8'h5F);
    read_byte(v); chk("R6 rd1 wrap", v, 8'h40);
    read_byte(v); chk("R6 rd2", v, 8'h41);
    do_stop();

    // R9/R10 burst with shadow capture
    chan_data_i = 64'h8877665544332211;
    do_start(0); send_byte(8'hCF); do_start(1);
    chan_data_i = 64'hDEADBEEFCAFEF00D;
    read_byte(v); chk("R9 count", v, 8'h08);
    for (int k = 0; k < 8; k++) begin
      read_byte(v); chk("R9 R10 chan", v, 8'h11 * 8'(k + 1));
    end
    read_byte(v); chk("R9 tail", v, 8'h00);
    do_stop();

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule